// File: doc/BRIEF.md
# Microprogram Sequencer with Bit-OR Dispatch

This block is the control unit of a single-bus processor, built as a microprogrammed engine. A microprogram counter addresses a small built-in control store. Each microword is split into encoded fields, and a field decoder turns those fields into one-hot bus-drive and register-load strobes, an ALU operation code and memory controls for the datapath.

Sequencing uses no dispatch table. A microword may name an explicit target and request that selected instruction-register bits be ORed into the low bits of that target. This dispatches on addressing mode at the end of instruction fetch, and on direct or indirect operand access later. A conditional form returns to the fetch routine when the negative flag is clear. Without a branch, the counter simply increments.

When a microword waits for memory and memory has not completed, the counter and every load strobe are frozen. An End microword sends the counter back to the fetch routine at address 0.

Top module: `ucode_seq`

## Requirements
- R1: While reset is asserted and after its release, the counter `upc` is 0. Word 0 drives `src_oe`=00001 (PC onto bus), `ld_a`=0001 (MAR), `ld_b`=00100 (Z), `mem_read`=1, `clear_y`=1, `carry_in`=1 and `alu_op`=0000 (ADD).
- R2: Fetch runs through addresses 0, 1, 2, 3. Word 1 drives Z onto the bus (`src_oe`=00100), loads PC (`ld_b`=00001) and asserts `wmfc`. Word 2 drives MDR (`src_oe`=00010) and loads IR (`ld_b`=00010).
- R3: While `wmfc`=1 and `mem_done`=0, `upc` holds its value at the next edge and `ld_a`, `ld_b` and `end_o` are all 0.
- R4: From address 3 the next address is 65 (octal 101). IR[10:9] are ORed into address bits 5:4, and the AND of IR[10], IR[9] and IR[8] is ORed into address bit 3.
- R5: Word 83 (octal 123) asserts `wmfc`. Once memory completes, the next address is 120 (octal 170) with IR[8] ORed into bit 0.
- R6: Operand tail: word 120 gives `src_oe`=00010, `ld_a`=0001, `mem_read`=1, `wmfc`=1; word 121 gives `src_oe`=00010, `ld_a`=1000 (Y); word 122 gives `src_oe`=10000 (Rdst), `ld_b`=00100, `alu_op`=0000; word 123 gives `src_oe`=00100, `ld_b`=10000 (Rdst), `end_o`=1.
- R7: After a cycle with `end_o`=1, `upc` is 0.
- R8: Word 97 (octal 141) drives PC onto the bus and loads Y. It goes to address 0 when `flag_n`=0 and to 98 when `flag_n`=1.
- R9: A microword with no branch, no End and no stall advances `upc` by one.
- R10: An unprogrammed address asserts `end_o`, drives no strobes (`src_oe`, `ld_a`, `ld_b` all 0) and returns to address 0.
- R11: Word 98 drives `alu_op`=1111 (XOR) and loads Z. Word 99 drives Z, loads PC and ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ir | input | IR_W | Instruction register contents |
| flag_n | input | 1 | Negative condition flag |
| mem_done | input | 1 | Memory operation complete |
| upc | output | 8 | Current microaddress |
| src_oe | output | 5 | One-hot bus drive: PC, MDR, Z, Rsrc, Rdst (bit 0 upward) |
| ld_a | output | 4 | One-hot load: MAR, MDR, TEMP, Y |
| ld_b | output | 5 | One-hot load: PC, IR, Z, Rsrc, Rdst |
| alu_op | output | 4 | ALU function code |
| mem_read | output | 1 | Memory read request |
| clear_y | output | 1 | Clear Y register |
| carry_in | output | 1 | ALU carry-in |
| wmfc | output | 1 | Wait for memory completion |
| end_o | output | 1 | End of instruction |

## Verification
The bench runs full instructions through all four IR[10:9] mode values and both IR[8] values. This separates the bit-5:4 OR from the bit-3 product term (mode 11 with IR[8] set reaches 121 rather than 113), and 170 from 171 at the second branch. Memory completion is withheld at both wait points, which checks the frozen counter and the gated strobes. The negative flag is run both ways at the conditional word, and mode 00 lands on an unprogrammed word to check the safe End path.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int UA_W        = 8;
  localparam int IR_MODE_LSB = 9;
  localparam int IR_IND_BIT  = 8;

  typedef struct packed {
    logic [UA_W-1:0] nxt;
    logic [2:0]      src;
    logic [2:0]      dst;
    logic [2:0]      dst2;
    logic [3:0]      alu;
    logic            jump;
    logic            ormode;
    logic            orindsrc;
    logic            cond_n0;
    logic            rd;
    logic            wmfc;
    logic            endf;
    logic            clry;
    logic            cin;
  } uword_t;

  function automatic uword_t ustore(input logic [UA_W-1:0] a);
    uword_t w;
    w = '0;
    case (a)
      8'o000: begin w.src = 3'd1; w.dst = 3'd1; w.dst2 = 3'd3; w.rd = 1'b1;
                    w.clry = 1'b1; w.cin = 1'b1; end
      8'o001: begin w.src = 3'd3; w.dst2 = 3'd1; w.wmfc = 1'b1; end
      8'o002: begin w.src = 3'd2; w.dst2 = 3'd2; end
      8'o003: begin w.jump = 1'b1; w.ormode = 1'b1; w.nxt = 8'o101; end
      8'o121: begin w.src = 3'd4; w.dst = 3'd1; w.dst2 = 3'd3; w.rd = 1'b1;
                    w.clry = 1'b1; w.cin = 1'b1; end
      8'o122: begin w.src = 3'd3; w.dst2 = 3'd4; end
      8'o123: begin w.jump = 1'b1; w.orindsrc = 1'b1; w.nxt = 8'o170;
                    w.wmfc = 1'b1; end
      8'o170: begin w.src = 3'd2; w.dst = 3'd1; w.rd = 1'b1; w.wmfc = 1'b1; end
      8'o171: begin w.src = 3'd2; w.dst = 3'd4; end
      8'o172: begin w.src = 3'd5; w.dst2 = 3'd3; end
      8'o173: begin w.src = 3'd3; w.dst2 = 3'd5; w.endf = 1'b1; end
      8'o141: begin w.src = 3'd1; w.dst = 3'd4; w.cond_n0 = 1'b1; w.nxt = 8'o000; end
      8'o142: begin w.dst2 = 3'd3; w.alu = 4'b1111; end
      8'o143: begin w.src = 3'd3; w.dst2 = 3'd1; w.endf = 1'b1; end
      default: w.endf = 1'b1;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
  import ucode_pkg::*;
(
  input  logic [UA_W-1:0] addr,
  output uword_t          word
);
  always_comb word = ustore(addr);
endmodule

// File: rtl/useq_next.sv
module useq_next
  import ucode_pkg::*;
(
  input  logic [UA_W-1:0] upc,
  input  uword_t          word,
  input  logic [1:0]      ir_mode,
  input  logic            ir_ind,
  input  logic            flag_n,
  input  logic            mem_done,
  output logic            stall,
  output logic [UA_W-1:0] nxt_upc
);
  logic [UA_W-1:0] or_mask;

  always_comb begin
    or_mask = '0;
    if (word.ormode) begin
      or_mask[5:4] = ir_mode;
      or_mask[3]   = ir_mode[1] & ir_mode[0] & ir_ind;
    end
    if (word.orindsrc)
      or_mask[0] = ir_ind;
  end

  always_comb begin
    stall = word.wmfc & ~mem_done;
    if (stall)
      nxt_upc = upc;
    else if (word.endf)
      nxt_upc = '0;
    else if (word.jump)
      nxt_upc = word.nxt | or_mask;
    else if (word.cond_n0 && !flag_n)
      nxt_upc = word.nxt;
    else
      nxt_upc = upc + 1'b1;
  end
endmodule

// File: rtl/ufield_dec.sv
module ufield_dec
  import ucode_pkg::*;
#(
  parameter int N_SRC  = 5,
  parameter int N_LDA  = 4,
  parameter int N_LDB  = 5
)(
  input  uword_t           word,
  input  logic             stall,
  output logic [N_SRC-1:0] src_oe,
  output logic [N_LDA-1:0] ld_a,
  output logic [N_LDB-1:0] ld_b,
  output logic [3:0]       alu_op,
  output logic             mem_read,
  output logic             clear_y,
  output logic             carry_in,
  output logic             wmfc,
  output logic             end_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign src_oe[i] = (word.src == 3'(i + 1));
  end
  for (genvar i = 0; i < N_LDA; i++) begin : g_lda
    assign ld_a[i] = (word.dst == 3'(i + 1)) & ~stall;
  end
  for (genvar i = 0; i < N_LDB; i++) begin : g_ldb
    assign ld_b[i] = (word.dst2 == 3'(i + 1)) & ~stall;
  end

  assign alu_op   = word.alu;
  assign mem_read = word.rd;
  assign clear_y  = word.clry;
  assign carry_in = word.cin;
  assign wmfc     = word.wmfc;
  assign end_o    = word.endf & ~stall;
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_pkg::*;
#(
  parameter int IR_W = 16
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IR_W-1:0] ir,
  input  logic            flag_n,
  input  logic            mem_done,
  output logic [UA_W-1:0] upc,
  output logic [4:0]      src_oe,
  output logic [3:0]      ld_a,
  output logic [4:0]      ld_b,
  output logic [3:0]      alu_op,
  output logic            mem_read,
  output logic            clear_y,
  output logic            carry_in,
  output logic            wmfc,
  output logic            end_o
);
  logic [1:0]      rst_sync;
  logic            rst_int_n;
  uword_t          word;
  logic            stall;
  logic [UA_W-1:0] nxt_upc;
  logic [UA_W-1:0] upc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ucode_rom i_rom (.addr(upc_q), .word(word));

  useq_next i_next (
    .upc(upc_q), .word(word),
    .ir_mode(ir[IR_MODE_LSB+1:IR_MODE_LSB]), .ir_ind(ir[IR_IND_BIT]),
    .flag_n(flag_n), .mem_done(mem_done),
    .stall(stall), .nxt_upc(nxt_upc)
  );

  ufield_dec i_dec (
    .word(word), .stall(stall),
    .src_oe(src_oe), .ld_a(ld_a), .ld_b(ld_b), .alu_op(alu_op),
    .mem_read(mem_read), .clear_y(clear_y), .carry_in(carry_in),
    .wmfc(wmfc), .end_o(end_o)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   upc_q <= '0;
    else if (!stall)  upc_q <= nxt_upc;
  end

  assign upc = upc_q;
endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk #(
  parameter int IR_W = 16
)(
  input logic            clk,
  input logic            rst_n,
  input logic [IR_W-1:0] ir,
  input logic            flag_n,
  input logic            mem_done,
  input logic [7:0]      upc,
  input logic [4:0]      src_oe,
  input logic [3:0]      ld_a,
  input logic [4:0]      ld_b,
  input logic            wmfc,
  input logic            end_o
);
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wmfc && !mem_done) |=> $stable(upc));
  // R3
  stall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wmfc && !mem_done) |-> (ld_a == 4'd0 && ld_b == 5'd0 && !end_o));
  // R7
  end_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> (upc == 8'd0));
  // R4
  mode_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 8'd3) |=> (upc == (8'd65 | {2'b00, $past(ir[10:9]),
                                  $past(ir[10] & ir[9] & ir[8]), 3'b000})));
  // R5
  ind_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 8'd83 && mem_done) |=> (upc == {7'd60, $past(ir[8])}));
  // R8
  cond_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == 8'd97 && !flag_n) |=> (upc == 8'd0));
  // R6
  onehot_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(src_oe) && $onehot0(ld_a) && $onehot0(ld_b)));
endmodule

bind ucode_seq ucode_seq_chk #(.IR_W(IR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .ir(ir), .flag_n(flag_n), .mem_done(mem_done),
  .upc(upc), .src_oe(src_oe), .ld_a(ld_a), .ld_b(ld_b),
  .wmfc(wmfc), .end_o(end_o)
);

// File: tb/test_ucode_seq.sv
`timescale 1ns/1ps
module test_ucode_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ir;
  logic        flag_n, mem_done;
  logic [7:0]  upc;
  logic [4:0]  src_oe, ld_b;
  logic [3:0]  ld_a, alu_op;
  logic        mem_read, clear_y, carry_in, wmfc, end_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ucode_seq #(.IR_W(16)) i_ucode_seq (
    .clk(clk), .rst_n(rst_n), .ir(ir), .flag_n(flag_n), .mem_done(mem_done),
    .upc(upc), .src_oe(src_oe), .ld_a(ld_a), .ld_b(ld_b), .alu_op(alu_op),
    .mem_read(mem_read), .clear_y(clear_y), .carry_in(carry_in),
    .wmfc(wmfc), .end_o(end_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic adv;
    @(posedge clk); #2;
  endtask

  task automatic fetch_from1;
    chk("R2 upc1", upc, 1);
    mem_done = 1'b0; #1;
    chk("R3 no load during wait", {ld_a, ld_b}, 0);
    adv;
    chk("R3 upc held", upc, 1);
    mem_done = 1'b1; #1;
    chk("R2 word1 strobes", {src_oe, ld_b, 4'(wmfc)}, {5'b00100, 5'b00001, 4'd1});
    adv;
    chk("R2 upc2", upc, 2);
    chk("R2 word2 strobes", {src_oe, ld_b}, {5'b00010, 5'b00010});
    adv;
    chk("R9 upc3", upc, 3);
    adv;
  endtask

  task automatic fetch;
    chk("R1 upc0", upc, 0);
    adv;
    fetch_from1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ir = '0; flag_n = 1'b0; mem_done = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset upc", upc, 0);
    chk("R1 reset word", {src_oe, ld_a, ld_b, alu_op, mem_read, clear_y, carry_in},
        {5'b00001, 4'b0001, 5'b00100, 4'b0000, 3'b111});
  endtask

  task automatic t_add_tail(input logic ind);
    ir = 16'h0000; ir[10:9] = 2'b01; ir[8] = ind;
    fetch;
    chk("R4 dispatch mode01", upc, 81);
    chk("R9 word121 strobes", {src_oe, ld_a, ld_b}, {5'b01000, 4'b0001, 5'b00100});
    adv;
    chk("R9 upc122", upc, 82);
    chk("R9 rsrc load", ld_b, 5'b01000);
    adv;
    chk("R5 upc123", upc, 83);
    mem_done = 1'b0; #1;
    chk("R5 wmfc at 123", wmfc, 1);
    adv;
    chk("R3 upc123 held", upc, 83);
    mem_done = 1'b1;
    adv;
    chk("R5 ind target", upc, ind ? 121 : 120);
    if (!ind) begin
      chk("R6 word170", {src_oe, ld_a, mem_read, wmfc}, {5'b00010, 4'b0001, 2'b11});
      adv;
      chk("R9 upc171", upc, 121);
    end
    chk("R6 word171", {src_oe, ld_a}, {5'b00010, 4'b1000});
    adv;
    chk("R6 word172", {src_oe, ld_b, alu_op}, {5'b10000, 5'b00100, 4'b0000});
    adv;
    chk("R6 word173", {src_oe, ld_b, 4'(end_o)}, {5'b00100, 5'b10000, 4'd1});
    adv;
    chk("R7 back to 0", upc, 0);
  endtask

  task automatic t_cond(input logic n);
    ir = 16'h0000; ir[10:9] = 2'b10; flag_n = n;
    fetch;
    chk("R4 dispatch mode10", upc, 97);
    chk("R8 word141", {src_oe, ld_a}, {5'b00001, 4'b1000});
    adv;
    if (!n) chk("R8 N=0 to 0", upc, 0);
    else begin
      chk("R8 N=1 to 98", upc, 98);
      chk("R11 xor word", {alu_op, ld_b}, {4'b1111, 5'b00100});
      adv;
      chk("R11 word143", {src_oe, ld_b, 4'(end_o)}, {5'b00100, 5'b00001, 4'd1});
      adv;
      chk("R7 after 143", upc, 0);
    end
    flag_n = 1'b0;
  endtask

  task automatic t_unprog;
    ir = 16'h0000;
    fetch;
    chk("R4 dispatch mode00", upc, 65);
    chk("R10 unprog word", {src_oe, ld_a, ld_b, 4'(end_o)}, {14'd0, 4'd1});
    adv;
    chk("R10 return 0", upc, 0);
    ir[10:9] = 2'b11; ir[8] = 1'b0;
    fetch;
    chk("R4 mode11 direct", upc, 113);
    chk("R10 unprog end", end_o, 1);
    adv;
    chk("R10 return 0 again", upc, 0);
  endtask

  task automatic t_mode11_ind;
    ir = 16'h0000; ir[10:9] = 2'b11; ir[8] = 1'b1;
    fetch;
    chk("R4 product term bit3", upc, 121);
    adv;
    chk("R9 upc122 after 121", upc, 122);
    adv; adv;
    chk("R7 mode11 done", upc, 0);
  endtask

  initial begin
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8 && upc != 8'd1; i++) adv;
    fetch_from1;
    chk("R4 first dispatch mode00", upc, 65);
    adv;
    chk("R10 first return", upc, 0);
    t_add_tail(1'b0);
    t_add_tail(1'b1);
    t_cond(1'b0);
    t_cond(1'b1);
    t_unprog;
    t_mode11_ind;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule